// File: doc/BRIEF.md
# Two-Stage Count-Clock Prescaler

This block turns a fast main oscillator clock into a slow count-clock enable, typically near 32.768 kHz, for a timekeeping counter. It does this in two stages. A binary stage divides by a power of two, 2^(m+1), where the selector m runs from 0 to 3. A modulo stage then divides by N, from 1 to 256. The output `tick_o` is a one-cycle enable pulse in the input clock domain, issued once every 2^(m+1) x N input clocks.

A 4 MHz input with m = 0 and a compare value of 61 gives a 122-clock period, which is about 32.787 kHz. Software works out m and N and drives them as static inputs. The block holds the values it is using in a shadow copy. That copy reloads only while the block is stopped or at the end of a full output period, so a change never produces a shortened or stretched period.

`enable_i` gates the whole divider. While it is low, both stage counters stay at zero and no pulse is issued. When it rises, counting starts again from zero.

Top module: `two_stage_prescaler`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `tick_o` is low and both stage counters are zero.
- R2: While enabled with a steady configuration, `tick_o` pulses once every P x N clocks, where P = 2^(m+1) for `pow_sel_i` = m (0 to 3) and N is the value of `modulus_i`. The first pulse is high in the cycle after the (P x N)-th rising edge at which `enable_i` is sampled high.
- R3: A `modulus_i` value of 8'h00 selects N = 256. For example, m = 3 with 8'h00 gives a period of 4096 clocks.
- R4: `tick_o` is never high for two consecutive cycles.
- R5: After a rising edge that samples `enable_i` low, `tick_o` is low. No pulse appears while `enable_i` stays low, even when the disable lands in the same cycle as a pulse.
- R6: When `enable_i` is raised again after a stop, counting restarts from zero. The first pulse comes P x N clocks after the first enabled edge, whatever point the counters had reached before the stop.
- R7: A change to `pow_sel_i` or `modulus_i` while running does not affect the period in progress. The values sampled at the edge that ends a period govern the next period. A change made in the cycle just before that edge is therefore adopted immediately.
- R8: With m = 0 and `modulus_i` = 8'h3D (N = 61), the pulse period is 122 clocks.
- R9: With `modulus_i` = 8'h01, the period is P alone: 2 clocks for m = 0 and 4 clocks for m = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run gate; low holds both stages at zero |
| pow_sel_i | input | 2 | Power-of-two selector m, divides by 2^(m+1) |
| modulus_i | input | 8 | Modulo value N; 8'h00 means 256 |
| tick_o | output | 1 | One-cycle count-clock enable pulse |

## Verification
Two functions can land on the same clock edge. The first pair is the end of a period and a configuration reload. The bench changes m and N once in the middle of a period, where the change must be ignored until the wrap. It changes them again in the cycle just before a wrap edge, where the new values must be taken at once. The scoreboard judges both cases by the exact cycle of every expected pulse.

The second pair is a pulse and a disable. The bench drops `enable_i` in the very cycle that `tick_o` is high. It then requires the output to be low one cycle later and to stay quiet for the rest of the stop window.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
// Shared defaults and types for the two-stage prescaler.
package cdiv_pkg;

    // Width of the power-of-two selector; the binary stage spans 2^POW_W bits.
    localparam int unsigned CDIV_POW_W = 2;
    // Width of the modulo compare value; an all-zero value stands for 2^MOD_W.
    localparam int unsigned CDIV_MOD_W = 8;

    // Registered state of the top-level output stage.
    typedef struct packed {
        logic tick;
    } cdiv_out_state_t;

endpackage

// File: rtl/cdiv_pow2_stage.sv
`timescale 1ns/1ps
// Binary stage: issues a stride pulse every 2^(sel+1) enabled clocks.
module cdiv_pow2_stage #(
    parameter int unsigned POW_W = cdiv_pkg::CDIV_POW_W,
    localparam int unsigned CNT_W = 1 << POW_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [POW_W-1:0] sel_i,
    output logic             stride_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] lim_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t state_d, state_q;
    logic [CNT_W-1:0] lim_w;

    // Terminal count has the low sel+1 bits set.
    for (genvar b = 0; b < CNT_W; b++) begin : g_lim
        assign lim_w[b] = (POW_W'(b) <= sel_i);
    end

    always_comb begin
        state_d  = state_q;
        stride_o = 1'b0;
        if (!run_i) begin
            state_d.cnt = '0;
        end else if (state_q.cnt == lim_w) begin
            stride_o    = 1'b1;
            state_d.cnt = '0;
        end else begin
            state_d.cnt = state_q.cnt + CNT_W'(1);
        end
        // Realign with the modulo stage at each full period.
        if (restart_i) begin
            state_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt_o = state_q.cnt;
    assign lim_o = lim_w;

endmodule

// File: rtl/cdiv_mod_stage.sv
`timescale 1ns/1ps
// Modulo stage: counts stride pulses and flags the N-th one as a wrap.
module cdiv_mod_stage #(
    parameter int unsigned MOD_W = cdiv_pkg::CDIV_MOD_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             stride_i,
    input  logic [MOD_W-1:0] mod_i,
    output logic             wrap_o,
    output logic [MOD_W-1:0] cnt_o
);

    typedef struct packed {
        logic [MOD_W-1:0] cnt;
    } state_t;

    state_t state_d, state_q;
    logic [MOD_W-1:0] last_w;

    // Subtracting one from zero gives all ones, so zero means 2^MOD_W.
    assign last_w = mod_i - MOD_W'(1);

    always_comb begin
        state_d = state_q;
        wrap_o  = 1'b0;
        if (!run_i) begin
            state_d.cnt = '0;
        end else if (stride_i) begin
            if (state_q.cnt == last_w) begin
                wrap_o      = 1'b1;
                state_d.cnt = '0;
            end else begin
                state_d.cnt = state_q.cnt + MOD_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt_o = state_q.cnt;

endmodule

// File: rtl/cdiv_cfg_hold.sv
`timescale 1ns/1ps
// Shadow copy of the divide settings.
// It follows the inputs while stopped and reloads only at a period boundary.
module cdiv_cfg_hold #(
    parameter int unsigned POW_W = cdiv_pkg::CDIV_POW_W,
    parameter int unsigned MOD_W = cdiv_pkg::CDIV_MOD_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             wrap_i,
    input  logic [POW_W-1:0] pow_i,
    input  logic [MOD_W-1:0] mod_i,
    output logic [POW_W-1:0] pow_o,
    output logic [MOD_W-1:0] mod_o
);

    typedef struct packed {
        logic [POW_W-1:0] pow;
        logic [MOD_W-1:0] modv;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (!run_i || wrap_i) begin
            state_d.pow  = pow_i;
            state_d.modv = mod_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pow_o = state_q.pow;
    assign mod_o = state_q.modv;

endmodule

// File: rtl/two_stage_prescaler.sv
`timescale 1ns/1ps
// Two-stage count-clock prescaler: binary stage, then modulo stage,
// then a registered one-cycle output pulse.
module two_stage_prescaler #(
    parameter int unsigned POW_W = cdiv_pkg::CDIV_POW_W,
    parameter int unsigned MOD_W = cdiv_pkg::CDIV_MOD_W,
    localparam int unsigned CNT_W = 1 << POW_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic [POW_W-1:0] pow_sel_i,
    input  logic [MOD_W-1:0] modulus_i,
    output logic             tick_o
);

    import cdiv_pkg::*;

    logic             stride_w;
    logic             wrap_w;
    logic [CNT_W-1:0] pow_cnt_w;
    logic [CNT_W-1:0] pow_lim_w;
    logic [MOD_W-1:0] mod_cnt_w;
    logic [POW_W-1:0] act_pow_w;
    logic [MOD_W-1:0] act_mod_w;

    cdiv_out_state_t out_d, out_q;

    cdiv_cfg_hold #(
        .POW_W(POW_W),
        .MOD_W(MOD_W)
    ) i_cfg_hold (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .run_i (enable_i),
        .wrap_i(wrap_w),
        .pow_i (pow_sel_i),
        .mod_i (modulus_i),
        .pow_o (act_pow_w),
        .mod_o (act_mod_w)
    );

    cdiv_pow2_stage #(
        .POW_W(POW_W)
    ) i_pow2_stage (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (enable_i),
        .restart_i(wrap_w),
        .sel_i    (act_pow_w),
        .stride_o (stride_w),
        .cnt_o    (pow_cnt_w),
        .lim_o    (pow_lim_w)
    );

    cdiv_mod_stage #(
        .MOD_W(MOD_W)
    ) i_mod_stage (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (enable_i),
        .stride_i(stride_w),
        .mod_i   (act_mod_w),
        .wrap_o  (wrap_w),
        .cnt_o   (mod_cnt_w)
    );

    always_comb begin
        out_d      = out_q;
        out_d.tick = wrap_w && enable_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign tick_o = out_q.tick;

endmodule

// File: rtl/cdiv_checker.sv
`timescale 1ns/1ps
// Property checker for the two-stage prescaler, attached by bind.
module cdiv_checker #(
    parameter int unsigned POW_W = cdiv_pkg::CDIV_POW_W,
    parameter int unsigned MOD_W = cdiv_pkg::CDIV_MOD_W,
    localparam int unsigned CNT_W = 1 << POW_W
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             enable_i,
    input logic             tick_o,
    input logic             stride_w,
    input logic             wrap_w,
    input logic [CNT_W-1:0] pow_cnt_w,
    input logic [CNT_W-1:0] pow_lim_w,
    input logic [MOD_W-1:0] mod_cnt_w,
    input logic [POW_W-1:0] act_pow_w,
    input logic [MOD_W-1:0] act_mod_w
);

    logic [MOD_W-1:0] mod_last_w;
    assign mod_last_w = act_mod_w - MOD_W'(1);

    // R1
    reset_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (!tick_o && pow_cnt_w == '0 && mod_cnt_w == '0));

    // R2
    pow_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pow_cnt_w <= pow_lim_w);

    // R2
    wrap_to_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_w |=> tick_o);

    // R3
    mod_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mod_cnt_w <= mod_last_w);

    // R4
    single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);

    // R5
    disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> !tick_o);

    // R5
    stride_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stride_w |-> enable_i);

    // R7
    cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(enable_i) && !$past(wrap_w)) |-> ($stable(act_pow_w) && $stable(act_mod_w)));

endmodule

bind two_stage_prescaler cdiv_checker #(
    .POW_W(POW_W),
    .MOD_W(MOD_W)
) i_cdiv_checker (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .tick_o   (tick_o),
    .stride_w (stride_w),
    .wrap_w   (wrap_w),
    .pow_cnt_w(pow_cnt_w),
    .pow_lim_w(pow_lim_w),
    .mod_cnt_w(mod_cnt_w),
    .act_pow_w(act_pow_w),
    .act_mod_w(act_mod_w)
);

// File: tb/test_two_stage_prescaler.sv
`timescale 1ns/1ps
module test_two_stage_prescaler;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       en;
    logic [1:0] pw;
    logic [7:0] md;
    logic       tick;

    int unsigned checks = 0;
    int unsigned fails  = 0;
    int          cyc    = 0;
    int          c0     = 0;
    int          seen   = 0;
    int          mon_e;
    int          exp_q[$];
    logic        prev_tick = 1'b0;
    string       tag = "R1";
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    two_stage_prescaler i_two_stage_prescaler (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .enable_i (en),
        .pow_sel_i(pw),
        .modulus_i(md),
        .tick_o   (tick)
    );

    // Monitor: pops expected pulse cycles and compares them against tick.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (exp_q.size() > 0 && cyc > exp_q[0]) begin
                checks++; fails++;
                $display("FAIL %s missing pulse: actual none, expected cycle %0d", tag, exp_q[0]);
                void'(exp_q.pop_front());
            end
            if (prev_tick) begin
                checks++;  // R4 single-cycle pulse
                if (tick) begin
                    fails++;
                    $display("FAIL R4 pulse width: actual tick=1 at cycle %0d, expected 0", cyc);
                end
            end
            if (tick) begin
                seen++;
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL %s unexpected pulse: actual cycle %0d, expected none", tag, cyc);
                end else begin
                    mon_e = exp_q.pop_front();
                    if (mon_e != cyc) begin
                        fails++;
                        $display("FAIL %s pulse time: actual cycle %0d, expected %0d", tag, cyc, mon_e);
                    end
                end
            end
            prev_tick = tick;
        end
    end

    always @(posedge clk) begin
        if (cyc == 150000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual cycle %0d, expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic step_to(input int t);
        while (cyc < t) step(1);
    endtask

    function automatic int period(input logic [1:0] m, input logic [7:0] n);
        return (2 ** (int'(m) + 1)) * ((n == 8'h00) ? 256 : int'(n));
    endfunction

    // Driver: programs the settings while stopped, starts, queues expected pulses.
    task automatic start(input logic [1:0] m, input logic [7:0] n, input string t, input int cnt);
        tag = t;
        pw  = m;
        md  = n;
        step(1);
        en = 1'b1;
        c0 = cyc;
        for (int k = 1; k <= cnt; k++) exp_q.push_back(c0 + k * period(m, n));
    endtask

    task automatic wait_done();
        while (exp_q.size() != 0) step(1);
        en = 1'b0;
        step(3);
    endtask

    task automatic check_bit(input string t, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %0b, expected %0b", t, act, expv);
        end
    endtask

    task automatic check_int(input string t, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d, expected %0d", t, act, expv);
        end
    endtask

    initial begin
        int s;
        rst_n = 1'b0;
        en    = 1'b0;
        pw    = 2'd0;
        md    = 8'd1;
        step(4);
        check_bit("R1 tick in reset", tick, 1'b0);
        rst_n = 1'b1;
        step(2);
        check_bit("R1 tick after reset", tick, 1'b0);

        // R8: m=0, N=61 gives 122 clocks
        start(2'd0, 8'h3D, "R8", 2);
        wait_done();

        // R2: sweep of the power-of-two selector
        for (int m = 1; m < 4; m++) begin
            start(2'(m), 8'd5, "R2", 2);
            wait_done();
        end

        // R9: N=1 leaves only the binary stage
        start(2'd0, 8'd1, "R9", 3);
        wait_done();
        start(2'd1, 8'd1, "R9", 3);
        wait_done();

        // R3: zero compare value means 256
        start(2'd0, 8'h00, "R3", 2);
        wait_done();
        start(2'd3, 8'h00, "R3", 2);
        wait_done();

        // R7: a mid-period change waits for the wrap; a change just before the wrap is taken
        start(2'd0, 8'd4, "R7", 1);
        step_to(c0 + 3);
        pw = 2'd1; md = 8'd3;
        exp_q.push_back(c0 + 20);
        exp_q.push_back(c0 + 32);
        step_to(c0 + 31);
        pw = 2'd0; md = 8'd2;
        exp_q.push_back(c0 + 36);
        exp_q.push_back(c0 + 40);
        wait_done();

        // R5: stop in mid-period; no pulse during the stop window
        start(2'd1, 8'd3, "R5", 0);
        step_to(c0 + 3);
        en = 1'b0;
        s  = seen;
        step(20);
        check_int("R5 pulses while stopped", seen, s);

        // R6: a restart counts from zero
        start(2'd1, 8'd3, "R6", 2);
        wait_done();

        // R5: disable in the same cycle as a pulse
        start(2'd0, 8'd3, "R5", 1);
        step_to(c0 + 6);
        check_bit("R5 pulse present", tick, 1'b1);
        en = 1'b0;
        step(1);
        check_bit("R5 pulse cleared after stop", tick, 1'b0);
        s = seen;
        step(12);
        check_int("R5 quiet after coincident stop", seen, s);
        check_int("R2 queue drained", exp_q.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule